// File: doc/BRIEF.md
# Quasi-Resonant Buck Switching-Period Controller

This block times the power switch of one buck cell in an LED driver. It gets a current-limit comparator flag, a zero-current flag taken from an auxiliary winding and an overvoltage comparator flag. It also gets a gain word and a dimming word, and it drives one registered gate output. In each switching cycle it counts the conduction time (T1) and the demagnetization time (T2). From their sum it computes the total period TT and holds the switch off until that period has run out.

TT is the measured T1 + T2, scaled up by the gain and divided by the dimming fraction. The dimming fraction has a lower clamp so that the quotient stays bounded. TT is never shorter than T1 + T2 and it saturates at the largest value the period counter can hold. Two watchdogs keep the switch cycling when the analog flags go quiet: one limits the on-time and one limits the wait for zero current. An overvoltage flag shuts the gate at once. The gate then stays low for one second, counted in clock cycles, after the last overvoltage sample, and switching then resumes.

Top module: `qr_buck_ctrl`

## Requirements
- R1: While `rst` is high, `gate_o` is low. At the first clock edge after `rst` falls, `gate_o` goes high, unless `ovp_i` is sampled high at that edge.
- R2: During conduction, `gate_o` goes low at the clock edge that samples `cs_trip_i` high. T1 is the number of cycles `gate_o` was high.
- R3: `gate_o` is never high for more than `MAX_ON_CYC` consecutive cycles. If `cs_trip_i` never asserts, the gate is forced low after exactly `MAX_ON_CYC` cycles.
- R4: T2 counts the low cycles from the gate's fall up to and including the cycle in which `zcd_i` is sampled high. If `zcd_i` is not seen within `ZCD_TIMEOUT` cycles, demagnetization is taken as ended with T2 = `ZCD_TIMEOUT`.
- R5: TT = floor((T1+T2) * gain * 2^(DIM_W-GAIN_FRAC) / dim_eff). Here `gain_i` is unsigned with `GAIN_FRAC` fraction bits, and `dim_i` is the fraction dim/2^DIM_W.
- R6: dim_eff = max(`dim_i`, ceil(2 * 2^DIM_W / 100)). This is 6 for DIM_W = 8, so a dimming word of 0 to 5 gives the same TT as 6.
- R7: TT is at least T1 + T2, even when the gain is below one, and it saturates at 2^CNT_W - 1.
- R8: The next turn-on waits for the end of demagnetization and for TT to elapse. The cycle count from one rise of `gate_o` to the next equals max(TT, T1+T2+1).
- R9: At the clock edge that samples `ovp_i` high, `gate_o` goes low, in any phase. It stays low while the fault lasts, whatever `cs_trip_i` and `zcd_i` do.
- R10: After the last edge that samples `ovp_i` high, `gate_o` stays low for exactly `CLK_HZ` cycles and then rises. An overvoltage sample during the fault restarts this count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_trip_i | input | 1 | Inductor current has reached its threshold |
| zcd_i | input | 1 | Auxiliary winding reports zero inductor current |
| ovp_i | input | 1 | Auxiliary winding voltage is above the overvoltage threshold |
| gain_i | input | GAIN_W | Period gain, unsigned, GAIN_FRAC fraction bits |
| dim_i | input | DIM_W | Dimming fraction, value/2^DIM_W |
| gate_o | output | 1 | Registered switch gate command |

## Verification
The bench builds the block with a 12-bit period counter and a 40-cycle restart delay standing in for one second. It uses a 20-cycle on-time limit and a 30-cycle zero-current timeout, with 8-bit gain (4 fraction bits) and 8-bit dimming. These small values make every corner reachable in a short run: periods saturate at 4095 cycles, gains below one hit the T1+T2 floor, and dimming words below 6 hit the clamp. The sweep crosses gains, dimming words and on/demagnetization lengths and compares each measured period with the formula. Directed runs then cover both timeouts, overvoltage in each phase and a restart delay reloaded during the fault.

// File: rtl/qr_buck_pkg.sv
package qr_buck_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ON    = 3'd1,
    ST_DEMAG = 3'd2,
    ST_WAIT  = 3'd3,
    ST_FAULT = 3'd4
  } qr_state_t;

endpackage

// File: rtl/qr_period_calc.sv
module qr_period_calc #(
  parameter int CNT_W     = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int DIM_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  sum_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [DIM_W-1:0]  dim_i,
  output logic [CNT_W-1:0]  tt_o
);

  localparam int NUM_W = CNT_W + GAIN_W + DIM_W;
  localparam int DEN_W = DIM_W + GAIN_FRAC;
  localparam logic [DIM_W-1:0] DIM_MIN = DIM_W'((2 * (2 ** DIM_W) + 99) / 100);
  localparam logic [NUM_W-1:0] TT_MAX  = NUM_W'((2 ** CNT_W) - 1);

  logic [DIM_W-1:0] dim_eff;
  logic [NUM_W-1:0] num;
  logic [DEN_W-1:0] den;
  logic [NUM_W-1:0] quo;
  logic [NUM_W-1:0] sum_ext;
  logic [CNT_W-1:0] tt_next;

  always_comb begin
    dim_eff = (dim_i < DIM_MIN) ? DIM_MIN : dim_i;
    sum_ext = NUM_W'(sum_i);
    num     = (sum_ext * NUM_W'(gain_i)) << DIM_W;
    den     = DEN_W'(dim_eff) << GAIN_FRAC;
    quo     = num / NUM_W'(den);
    if (quo > TT_MAX)       tt_next = TT_MAX[CNT_W-1:0];
    else if (quo < sum_ext) tt_next = sum_i;
    else                    tt_next = quo[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         tt_o <= '0;
    else if (load_i) tt_o <= tt_next;
  end

  // R7: a loaded period never undercuts the measured T1+T2
  p_tt_floor_r7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (tt_o >= $past(sum_i)));

endmodule

// File: rtl/qr_restart_timer.sv
module qr_restart_timer #(
  parameter int CLK_HZ = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);

  localparam int RC_W = $clog2(CLK_HZ + 1);
  localparam logic [RC_W-1:0] RELOAD = RC_W'(CLK_HZ - 1);

  logic [RC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load_i)               cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R10: a fresh overvoltage sample always pushes the restart out by a full delay
  generate
    if (CLK_HZ > 1) begin : g_reload_chk
      p_reload_r10: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !done_o);
    end
  endgenerate

endmodule

// File: rtl/qr_buck_ctrl.sv
module qr_buck_ctrl
  import qr_buck_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int GAIN_W      = 8,
  parameter int GAIN_FRAC   = 4,
  parameter int DIM_W       = 8,
  parameter int CLK_HZ      = 1_000_000,
  parameter int MAX_ON_CYC  = 1000,
  parameter int ZCD_TIMEOUT = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_trip_i,
  input  logic              zcd_i,
  input  logic              ovp_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [DIM_W-1:0]  dim_i,
  output logic              gate_o
);

  localparam int DC_W = $clog2(ZCD_TIMEOUT + 1);
  localparam logic [CNT_W:0]  ON_LIM  = (CNT_W+1)'(MAX_ON_CYC);
  localparam logic [DC_W-1:0] ZCD_LIM = DC_W'(ZCD_TIMEOUT);

  qr_state_t        st_q;
  logic [CNT_W-1:0] pc_q;
  logic [DC_W-1:0]  dc_q;
  logic             gate_q;

  logic [CNT_W:0]   pc_inc;
  logic [DC_W-1:0]  dc_inc;
  logic             on_end;
  logic             demag_end;
  logic             period_up;
  logic [CNT_W-1:0] tt;
  logic             rt_done;
  logic             calc_load;

  always_comb begin
    pc_inc    = {1'b0, pc_q} + 1'b1;
    dc_inc    = dc_q + 1'b1;
    on_end    = cs_trip_i || (pc_inc == ON_LIM);
    demag_end = zcd_i || (dc_inc == ZCD_LIM);
    period_up = (pc_inc >= {1'b0, tt});
    calc_load = (st_q == ST_DEMAG) && demag_end && !ovp_i;
  end

  qr_period_calc #(
    .CNT_W     (CNT_W),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC),
    .DIM_W     (DIM_W)
  ) u_calc (
    .clk    (clk),
    .rst    (rst),
    .load_i (calc_load),
    .sum_i  (pc_inc[CNT_W-1:0]),
    .gain_i (gain_i),
    .dim_i  (dim_i),
    .tt_o   (tt)
  );

  qr_restart_timer #(
    .CLK_HZ (CLK_HZ)
  ) u_restart (
    .clk    (clk),
    .rst    (rst),
    .load_i (ovp_i),
    .run_i  (st_q == ST_FAULT),
    .done_o (rt_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      gate_q <= 1'b0;
      pc_q   <= '0;
      dc_q   <= '0;
    end else if (ovp_i) begin
      st_q   <= ST_FAULT;
      gate_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q   <= ST_ON;
          gate_q <= 1'b1;
          pc_q   <= '0;
        end
        ST_ON: begin
          pc_q <= pc_inc[CNT_W-1:0];
          if (on_end) begin
            st_q   <= ST_DEMAG;
            gate_q <= 1'b0;
            dc_q   <= '0;
          end
        end
        ST_DEMAG: begin
          pc_q <= pc_inc[CNT_W-1:0];
          dc_q <= dc_inc;
          if (demag_end) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (period_up) begin
            st_q   <= ST_ON;
            gate_q <= 1'b1;
            pc_q   <= '0;
          end else begin
            pc_q <= pc_inc[CNT_W-1:0];
          end
        end
        ST_FAULT: begin
          if (rt_done) begin
            st_q   <= ST_ON;
            gate_q <= 1'b1;
            pc_q   <= '0;
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          gate_q <= 1'b0;
        end
      endcase
    end
  end

  assign gate_o = gate_q;

  // R2: a sampled current trip ends conduction at that edge
  p_trip_off_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ON && cs_trip_i) |=> !gate_o);

  // R3: the conduction count never reaches the on-time limit while the gate is high
  p_max_on_r3: assert property (@(posedge clk) disable iff (rst)
    gate_o |-> ({1'b0, pc_q} < ON_LIM));

  // R4: demagnetization never outlasts its timeout
  p_demag_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DEMAG) |-> (dc_q < ZCD_LIM));

  // R8: no turn-on before the computed period has elapsed
  p_no_early_on_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !period_up) |=> !gate_o);

  // R9: overvoltage forces the gate low at the next edge
  p_ovp_off_r9: assert property (@(posedge clk) disable iff (rst)
    ovp_i |=> !gate_o);

  // R10: the gate holds low until the restart delay completes
  p_fault_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FAULT && !rt_done) |=> !gate_o);

endmodule

// File: tb/qr_buck_ctrl_tb.sv
module qr_buck_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int GAIN_W     = 8;
  localparam int GAIN_FRAC  = 4;
  localparam int DIM_W      = 8;
  localparam int CLK_HZ     = 40;
  localparam int MAX_ON     = 20;
  localparam int ZCD_TO     = 30;
  localparam int DIM_FLOOR  = 6;
  localparam int TT_SAT     = 4095;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_trip = 1'b0;
  logic zcd = 1'b0;
  logic ovp = 1'b0;
  logic [GAIN_W-1:0] gain = 8'd16;
  logic [DIM_W-1:0]  dim  = 8'd255;
  logic gate;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  qr_buck_ctrl #(
    .CNT_W       (CNT_W),
    .GAIN_W      (GAIN_W),
    .GAIN_FRAC   (GAIN_FRAC),
    .DIM_W       (DIM_W),
    .CLK_HZ      (CLK_HZ),
    .MAX_ON_CYC  (MAX_ON),
    .ZCD_TIMEOUT (ZCD_TO)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .cs_trip_i (cs_trip),
    .zcd_i     (zcd),
    .ovp_i     (ovp),
    .gain_i    (gain),
    .dim_i     (dim),
    .gate_o    (gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog R8: actual=%0d cycles expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered at the negedge showing the first high cycle of a period; returns at the next one.
  task automatic run_cycle(input int t1r, input int t2r, input int g, input int d);
    int hi, lo, et1, et2, s, de, q, ep;
    string tag;
    gain = g[GAIN_W-1:0];
    dim  = d[DIM_W-1:0];
    hi = 1;
    while (1) begin
      if (hi == t1r) cs_trip = 1'b1;
      @(negedge clk);
      cs_trip = 1'b0;
      if (!gate) break;
      hi++;
      if (hi > 200) break;
    end
    et1 = (t1r == 0 || t1r > MAX_ON) ? MAX_ON : t1r;
    check(hi == et1, (t1r == 0) ? "R3 on-time limit" : "R2 trip on-time", hi, et1);
    lo = 1;
    while (1) begin
      if (lo == t2r) zcd = 1'b1;
      @(negedge clk);
      zcd = 1'b0;
      if (gate) break;
      lo++;
      if (lo > 5000) break;
    end
    et2 = (t2r == 0 || t2r > ZCD_TO) ? ZCD_TO : t2r;
    s  = et1 + et2;
    de = (d < DIM_FLOOR) ? DIM_FLOOR : d;
    q  = (s * g * 16) / de;
    if (q < s) q = s;
    if (q > TT_SAT) q = TT_SAT;
    ep = (q > s + 1) ? q : s + 1;
    if (t2r == 0)          tag = "R4 zcd timeout period";
    else if (q == TT_SAT)  tag = "R7 saturated period";
    else if (q == s)       tag = "R7 floor period";
    else if (d < DIM_FLOOR) tag = "R6 clamped dim period";
    else                   tag = "R5 R8 period";
    check(hi + lo == ep, tag, hi + lo, ep);
  endtask

  // Entered at a negedge; ovp is sampled at the next edge. Counts low cycles until restart.
  task automatic ovp_run(input int pulse_at, input int exp);
    int lo;
    ovp = 1'b1;
    @(negedge clk);
    ovp = 1'b0;
    check(gate == 1'b0, "R9 gate low after ovp", gate, 0);
    lo = 1;
    while (1) begin
      if (lo == pulse_at) ovp = 1'b1;
      if (lo == 2) begin cs_trip = 1'b1; zcd = 1'b1; end
      if (lo == 4) begin cs_trip = 1'b0; zcd = 1'b0; end
      @(negedge clk);
      ovp = 1'b0;
      if (gate) break;
      lo++;
      if (lo > 1000) break;
    end
    check(lo == exp, "R10 restart delay", lo, exp);
  endtask

  initial begin
    int gains [4] = '{8, 16, 40, 255};
    int dims  [6] = '{255, 128, 64, 13, 6, 2};
    int t1s   [2] = '{1, 5};
    int t2s   [2] = '{1, 4};

    repeat (3) @(negedge clk);
    check(gate == 1'b0, "R1 gate low in reset", gate, 0);
    rst = 1'b0;
    @(negedge clk);
    check(gate == 1'b1, "R1 first turn-on after reset", gate, 1);

    foreach (gains[gi])
      foreach (dims[di])
        foreach (t1s[ai])
          foreach (t2s[bi])
            run_cycle(t1s[ai], t2s[bi], gains[gi], dims[di]);

    run_cycle(0, 3, 16, 255);
    run_cycle(4, 0, 16, 255);
    run_cycle(0, 0, 40, 128);
    run_cycle(3, 7, 24, 0);

    ovp_run(0, CLK_HZ);
    ovp_run(10, 10 + CLK_HZ);

    cs_trip = 1'b1;
    @(negedge clk);
    cs_trip = 1'b0;
    check(gate == 1'b0, "R2 gate off before demag ovp", gate, 0);
    ovp_run(0, CLK_HZ);

    run_cycle(3, 2, 16, 255);
    run_cycle(2, 2, 32, 128);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule